// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block turns decoded memory requests into SDRAM commands, one request at a time. Each request names a bank, a row, a column, a direction and an optional auto-precharge flag. The sequencer remembers which row is open in every bank. From that record it picks the shortest legal command chain: a lone column command for a row hit, activate plus column for an idle bank, or precharge, activate and column when another row is open.

All device spacings come in as programmable cycle counts: activate-to-column, precharge-to-activate, CAS latency, write recovery, write-to-read turnaround, refresh interval and refresh duration. The block waits out each one before it issues a dependent command. A periodic refresh takes precedence over new work. It closes every bank with a single precharge-all, then issues the refresh command and holds the request port off until the refresh period has elapsed.

A one-cycle done strobe marks the point, CAS latency after the column command, at which the data of a request would be on the bus. Data capture, I/O timing, device initialisation and power-down belong to other blocks.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5 (precharge all banks), REF=6. After reset `cmd_o` is NOP, `req_ready_o` is high and `done_o` is low.
- R2: A request to the row already open in its bank produces only a RD or WR command, driven on `cmd_o` in the first cycle after the accepting clock edge.
- R3: A request to a bank with no open row produces ACT (carrying the row) in the first cycle after acceptance, then the column command `t_rcd_i` cycles after the ACT.
- R4: A request to a bank holding a different row produces PRE in the first cycle after acceptance, ACT `t_rp_i` cycles after it, and the column command `t_rcd_i` cycles after the ACT.
- R5: `done_o` pulses for exactly one cycle, `t_cl_i` cycles after each RD or WR command.
- R6: While a row hit is being issued, the next request is accepted in the same cycle, so row hits produce one column command per cycle.
- R7: A PRE to a bank comes no earlier than `t_wr_i` cycles after a WR to that bank.
- R8: A RD comes no earlier than `t_wtr_i` cycles after any WR.
- R9: A column command with `req_autopre_i` set closes its row. The next ACT to that bank comes `t_rp_i` cycles after a read, or `t_wr_i + t_rp_i` cycles after a write, with no PRE issued.
- R10: A refresh falls due every `t_ref_i` cycles. From that point `req_ready_o` stays low. If any bank is open, PREA is issued first, then REF `t_rp_i` cycles later, and `req_ready_o` rises again `t_rfc_i` cycles after the REF.
- R11: Reset, precharge and refresh clear the open-row records, so a request to a row that was open before a refresh takes the ACT path.
- R12: At most one command is issued per cycle and `cmd_o` never carries an undefined code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_bank_i | input | BA_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_autopre_i | input | 1 | Close the row after the column access |
| t_rcd_i | input | TW | Activate to column spacing |
| t_rp_i | input | TW | Precharge to activate spacing |
| t_cl_i | input | TW | Column command to data (at least 1) |
| t_wr_i | input | TW | Write to precharge spacing |
| t_wtr_i | input | TW | Write to read spacing |
| t_rfc_i | input | TW | Refresh busy time |
| t_ref_i | input | REF_W | Refresh interval |
| cmd_o | output | 3 | Command code |
| cmd_bank_o | output | BA_W | Command bank |
| cmd_row_o | output | ROW_W | Row for ACT |
| cmd_col_o | output | COL_W | Column for RD/WR |
| cmd_autopre_o | output | 1 | Auto-precharge flag with RD/WR |
| done_o | output | 1 | Request data point strobe |

## Verification
The two functions that collide are the pipelined acceptance of a new request and the timing gate that a column write places on the command that follows. A write that hits an open row lets the next request in during the cycle the write issues. That next request then has to wait on the write's recovery or turnaround counters. The bench provokes this with back-to-back request pairs: write then read to the same row, write then a conflicting row, and auto-precharged write then the same row. It checks that the second request was accepted without a bubble, and that its PRE, ACT or RD lands exactly on the `t_wtr_i`, `t_wr_i` or `t_wr_i + t_rp_i` boundary. A second collision, a refresh falling due while a request is held valid, is judged by `req_ready_o` staying low through PREA, REF and the busy time.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SERVE,
    ST_RFSH,
    ST_RBUSY
  } seq_st_e;
endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int ROW_W = 13,
  parameter int TW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             autopre_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [TW-1:0]    t_rcd_i,
  input  logic [TW-1:0]    t_rp_i,
  input  logic [TW-1:0]    t_wr_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             col_ok_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);
  localparam int CW = TW + 1;

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    rcd_q, rp_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      rp_q   <= '0;
      wr_q   <= '0;
    end else begin
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
      if (wr_q  != '0) wr_q  <= wr_q  - 1'b1;
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        rcd_q  <= {1'b0, t_rcd_i};
      end
      if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= {1'b0, t_rp_i};
      end
      if (rd_i && autopre_i) begin
        open_q <= 1'b0;
        rp_q   <= {1'b0, t_rp_i};
      end
      if (wr_i) begin
        wr_q <= {1'b0, t_wr_i};
        // auto-precharge after write waits out recovery, then the precharge itself
        if (autopre_i) begin
          open_q <= 1'b0;
          rp_q   <= {1'b0, t_wr_i} + {1'b0, t_rp_i};
        end
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign col_ok_o = (rcd_q <= CW'(1));
  assign pre_ok_o = (wr_q  <= CW'(1));
  assign act_ok_o = (rp_q  <= CW'(1));

  // R3
  act_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (!open_q && rp_q <= CW'(1)));

  // R2
  col_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) |-> (open_q && rcd_q <= CW'(1)));

  // R7
  pre_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> (wr_q <= CW'(1)));
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REF_W-1:0] t_ref_i,
  output logic             due_o
);
  logic [REF_W-1:0] cnt_q;

  assign due_o = ({1'b0, cnt_q} + (REF_W+1)'(1)) >= {1'b0, t_ref_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (due_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdram_done_pipe.sv
module sdram_done_pipe #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [TW-1:0] t_cl_i,
  output logic          done_o
);
  localparam int DEPTH = 1 << TW;

  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], fire_i};
  end

  // bit k holds a column command issued k cycles ago
  assign done_o = sr_q[t_cl_i];

  // R5
  done_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> sr_q[0]);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int TW        = 4,
  parameter int REF_W     = 12,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [BA_W-1:0]  req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_write_i,
  input  logic             req_autopre_i,
  input  logic [TW-1:0]    t_rcd_i,
  input  logic [TW-1:0]    t_rp_i,
  input  logic [TW-1:0]    t_cl_i,
  input  logic [TW-1:0]    t_wr_i,
  input  logic [TW-1:0]    t_wtr_i,
  input  logic [TW-1:0]    t_rfc_i,
  input  logic [REF_W-1:0] t_ref_i,
  output logic [2:0]       cmd_o,
  output logic [BA_W-1:0]  cmd_bank_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             cmd_autopre_o,
  output logic             done_o
);
  seq_st_e st_q, st_d;

  logic [BA_W-1:0]  bq;
  logic [ROW_W-1:0] rowq;
  logic [COL_W-1:0] colq;
  logic             wrq, apq;

  logic col_fire, act_fire, pre_fire, prea_fire, ref_fire, accept;
  logic [NUM_BANKS-1:0] bk_open, bk_col_ok, bk_pre_ok, bk_act_ok;
  logic [ROW_W-1:0]     bk_row [NUM_BANKS];
  logic [TW-1:0]        wtr_q, rfc_q;
  logic                 ref_due, ref_pend_q;
  logic                 hit, any_open, all_pre_ok, all_act_ok, wtr_ok, rfc_end;

  cmd_e             cmd_q;
  logic [BA_W-1:0]  cmd_bank_q;
  logic [ROW_W-1:0] cmd_row_q;
  logic [COL_W-1:0] cmd_col_q;
  logic             cmd_ap_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (bq == BA_W'(g));
    sdram_bank_track #(.ROW_W(ROW_W), .TW(TW)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act_fire && sel),
      .pre_i     ((pre_fire && sel) || prea_fire),
      .rd_i      (col_fire && sel && !wrq),
      .wr_i      (col_fire && sel && wrq),
      .autopre_i (apq),
      .row_i     (rowq),
      .t_rcd_i   (t_rcd_i),
      .t_rp_i    (t_rp_i),
      .t_wr_i    (t_wr_i),
      .open_o    (bk_open[g]),
      .row_o     (bk_row[g]),
      .col_ok_o  (bk_col_ok[g]),
      .pre_ok_o  (bk_pre_ok[g]),
      .act_ok_o  (bk_act_ok[g])
    );
  end

  sdram_ref_timer #(.REF_W(REF_W)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .t_ref_i (t_ref_i),
    .due_o   (ref_due)
  );

  sdram_done_pipe #(.TW(TW)) u_done (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (col_fire),
    .t_cl_i (t_cl_i),
    .done_o (done_o)
  );

  assign hit        = bk_open[bq] && (bk_row[bq] == rowq);
  assign any_open   = |bk_open;
  assign all_pre_ok = &bk_pre_ok;
  assign all_act_ok = &bk_act_ok;
  assign wtr_ok     = (wtr_q <= TW'(1));
  assign rfc_end    = (st_q == ST_RBUSY) && (rfc_q <= TW'(1));

  // command selection, independent of the incoming request
  always_comb begin
    col_fire  = 1'b0;
    act_fire  = 1'b0;
    pre_fire  = 1'b0;
    prea_fire = 1'b0;
    ref_fire  = 1'b0;
    unique case (st_q)
      ST_SERVE: begin
        if (bk_open[bq]) begin
          if (hit) col_fire = bk_col_ok[bq] && (wrq || wtr_ok);
          else     pre_fire = bk_pre_ok[bq];
        end else begin
          act_fire = bk_act_ok[bq];
        end
      end
      ST_RFSH: begin
        if (any_open) prea_fire = all_pre_ok;
        else          ref_fire  = all_act_ok;
      end
      default: ;
    endcase
  end

  assign req_ready_o = !ref_pend_q && ((st_q == ST_IDLE) || col_fire);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_SERVE;
                else if (ref_pend_q) st_d = ST_RFSH;
      ST_SERVE: if (col_fire) st_d = accept ? ST_SERVE : ST_IDLE;
      ST_RFSH:  if (ref_fire) st_d = ST_RBUSY;
      ST_RBUSY: if (rfc_end) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bq         <= '0;
      rowq       <= '0;
      colq       <= '0;
      wrq        <= 1'b0;
      apq        <= 1'b0;
      wtr_q      <= '0;
      rfc_q      <= '0;
      ref_pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        bq   <= req_bank_i;
        rowq <= req_row_i;
        colq <= req_col_i;
        wrq  <= req_write_i;
        apq  <= req_autopre_i;
      end
      if (wtr_q != '0) wtr_q <= wtr_q - 1'b1;
      if (col_fire && wrq) wtr_q <= t_wtr_i;
      if (rfc_q != '0) rfc_q <= rfc_q - 1'b1;
      if (ref_fire) rfc_q <= t_rfc_i;
      if (rfc_end) ref_pend_q <= 1'b0;
      if (ref_due) ref_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= CMD_NOP;
      cmd_bank_q <= '0;
      cmd_row_q  <= '0;
      cmd_col_q  <= '0;
      cmd_ap_q   <= 1'b0;
    end else begin
      if (col_fire)       cmd_q <= wrq ? CMD_WR : CMD_RD;
      else if (act_fire)  cmd_q <= CMD_ACT;
      else if (pre_fire)  cmd_q <= CMD_PRE;
      else if (prea_fire) cmd_q <= CMD_PREA;
      else if (ref_fire)  cmd_q <= CMD_REF;
      else                cmd_q <= CMD_NOP;
      cmd_bank_q <= bq;
      cmd_row_q  <= rowq;
      cmd_col_q  <= colq;
      cmd_ap_q   <= col_fire && apq;
    end
  end

  assign cmd_o         = cmd_q;
  assign cmd_bank_o    = cmd_bank_q;
  assign cmd_row_o     = cmd_row_q;
  assign cmd_col_o     = cmd_col_q;
  assign cmd_autopre_o = cmd_ap_q;

  // R12
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({col_fire, act_fire, pre_fire, prea_fire, ref_fire}));

  // R10
  ref_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_fire |-> !any_open);

  // R10
  ref_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'(CMD_REF)) |-> !req_ready_o);

  // R8
  wtr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'(CMD_WR) && t_wtr_i > TW'(1)) |=> (cmd_o != 3'(CMD_RD)));
endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
  localparam int NB = 4, ROW_W = 13, COL_W = 10, TW = 4, REF_W = 12;
  localparam int T_RCD = 3, T_RP = 2, T_CL = 4, T_WR = 5, T_WTR = 3, T_RFC = 6;
  localparam int NV = 11;
  // kind: 0 hit, 1 closed, 2 conflict, 3 closed after auto-precharge
  localparam int V_BANK [NV] = '{0, 0, 0, 1, 1, 1, 2, 2, 0, 3, 3};
  localparam int V_ROW  [NV] = '{5, 5, 9, 3, 3, 3, 7, 7, 9, 1, 2};
  localparam int V_COL  [NV] = '{4, 8, 12, 16, 20, 24, 28, 32, 36, 40, 44};
  localparam int V_WR   [NV] = '{0, 0, 1, 0, 1, 0, 0, 1, 0, 1, 0};
  localparam int V_AP   [NV] = '{0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0};
  localparam int V_KIND [NV] = '{1, 0, 2, 1, 0, 3, 1, 3, 0, 1, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_write = 1'b0, req_ap = 1'b0;
  logic [REF_W-1:0] t_ref = REF_W'(4095);
  logic [2:0] cmd;
  logic [1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic cmd_ap, done;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sdram_cmd_seq #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .TW(TW), .REF_W(REF_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_write_i(req_write), .req_autopre_i(req_ap),
    .t_rcd_i(TW'(T_RCD)), .t_rp_i(TW'(T_RP)), .t_cl_i(TW'(T_CL)),
    .t_wr_i(TW'(T_WR)), .t_wtr_i(TW'(T_WTR)), .t_rfc_i(TW'(T_RFC)),
    .t_ref_i(t_ref),
    .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .cmd_autopre_o(cmd_ap), .done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int b, input int r, input int c, input int w, input int a);
    req_bank = 2'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
    req_write = 1'(w); req_ap = 1'(a); req_valid = 1'b1;
  endtask

  task automatic send(input int b, input int r, input int c, input int w, input int a);
    @(negedge clk);
    drive(b, r, c, w, a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scan from the negedge after the accepting edge until a column command
  task automatic measure(output int pre_k, output int act_k, output int col_k,
                         output int ncmd, output int act_row, output int ccmd,
                         output int cbank, output int ccol);
    pre_k = -1; act_k = -1; col_k = -1; ncmd = 0;
    act_row = -1; ccmd = -1; cbank = -1; ccol = -1;
    for (int k = 1; k <= 40 && col_k < 0; k++) begin
      @(negedge clk);
      if (cmd > 3'd6) chk("R12 code", int'(cmd), 0);
      if (cmd != 3'd0) ncmd++;
      if (cmd == 3'd4 && pre_k < 0) pre_k = k;
      if (cmd == 3'd1 && act_k < 0) begin act_k = k; act_row = int'(cmd_row); end
      if (cmd == 3'd2 || cmd == 3'd3) begin
        col_k = k; ccmd = int'(cmd); cbank = int'(cmd_bank); ccol = int'(cmd_col);
      end
    end
  endtask

  task automatic pair(input int b1, input int r1, input int c1, input int w1, input int a1,
                      input int b2, input int r2, input int c2, input int w2, input int a2,
                      output int first_cmd, output int pre_k, output int act_k,
                      output int col_k, output int ccol);
    int ncmd, arow, ccmd, cbank;
    @(negedge clk);
    drive(b1, r1, c1, w1, a1);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    drive(b2, r2, c2, w2, a2);
    chk("R6 next request taken with hit", int'(req_ready), 1);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first_cmd = int'(cmd);
    measure(pre_k, act_k, col_k, ncmd, arow, ccmd, cbank, ccol);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pk, ak, ck, nc, ar, cc, cb, ccol, fc, pa, rf, cyc;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd", int'(cmd), 0);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 done", int'(done), 0);

    for (int i = 0; i < NV; i++) begin
      send(V_BANK[i], V_ROW[i], V_COL[i], V_WR[i], V_AP[i]);
      measure(pk, ak, ck, nc, ar, cc, cb, ccol);
      case (V_KIND[i])
        0: begin
          tag = "R2";
          chk({tag, " col cycle"}, ck, 1);
          chk({tag, " cmd count"}, nc, 1);
        end
        1, 3: begin
          tag = (V_KIND[i] == 3) ? "R9" : "R3";
          chk({tag, " act cycle"}, ak, 1);
          chk({tag, " act row"}, ar, V_ROW[i]);
          chk({tag, " col cycle"}, ck, 1 + T_RCD);
          chk({tag, " cmd count"}, nc, 2);
        end
        default: begin
          tag = "R4";
          chk({tag, " pre cycle"}, pk, 1);
          chk({tag, " act cycle"}, ak, 1 + T_RP);
          chk({tag, " col cycle"}, ck, 1 + T_RP + T_RCD);
          chk({tag, " cmd count"}, nc, 3);
        end
      endcase
      chk({tag, " col code"}, cc, V_WR[i] != 0 ? 3 : 2);
      chk({tag, " col bank"}, cb, V_BANK[i]);
      chk({tag, " col addr"}, ccol, V_COL[i]);
      // R5 done strobe at t_cl after the column command
      for (int j = 1; j <= T_CL; j++) begin
        @(negedge clk);
        chk("R5 done", int'(done), (j == T_CL) ? 1 : 0);
      end
      @(negedge clk);
      chk("R5 done pulse width", int'(done), 0);
      repeat (16) @(negedge clk);
    end

    // R6 two reads to open row b0 r9, one column command per cycle
    pair(0, 9, 100, 0, 0, 0, 9, 101, 0, 0, fc, pk, ak, ck, ccol);
    chk("R6 first col", fc, 2);
    chk("R6 second col cycle", ck, 1);
    chk("R6 second col addr", ccol, 101);
    repeat (16) @(negedge clk);

    // R8 write then read to same open row
    pair(0, 9, 110, 1, 0, 0, 9, 111, 0, 0, fc, pk, ak, ck, ccol);
    chk("R8 first col", fc, 3);
    chk("R8 read after wtr", ck, T_WTR);
    repeat (16) @(negedge clk);

    // R7 write to b1 r3, then conflicting row in b1
    pair(1, 3, 120, 1, 0, 1, 4, 121, 0, 0, fc, pk, ak, ck, ccol);
    chk("R7 first col", fc, 3);
    chk("R7 pre after wr", pk, T_WR);
    chk("R7 act", ak, T_WR + T_RP);
    chk("R7 col", ck, T_WR + T_RP + T_RCD);
    repeat (16) @(negedge clk);

    // R9 write with auto-precharge to b1 r4, then same row again
    pair(1, 4, 130, 1, 1, 1, 4, 131, 0, 0, fc, pk, ak, ck, ccol);
    chk("R9 first col", fc, 3);
    chk("R9 no explicit pre", pk, -1);
    chk("R9 act after wr+rp", ak, T_WR + T_RP);
    chk("R9 col", ck, T_WR + T_RP + T_RCD);
    repeat (16) @(negedge clk);

    // R10 refresh: shorten the interval so it falls due at once
    @(negedge clk);
    t_ref = REF_W'(20);
    @(negedge clk);
    chk("R10 ready low when due", int'(req_ready), 0);
    drive(0, 9, 140, 0, 0);
    pa = -1; rf = -1; cyc = 0;
    while (!req_ready && cyc < 100) begin
      if (cmd == 3'd5 && pa < 0) pa = cyc;
      if (cmd == 3'd6 && rf < 0) begin rf = cyc; t_ref = REF_W'(4095); end
      @(negedge clk);
      cyc++;
    end
    chk("R10 prea seen", int'(pa >= 0), 1);
    chk("R10 ref after rp", rf - pa, T_RP);
    chk("R10 ready after rfc", cyc - rf, T_RFC);
    @(negedge clk);
    req_valid = 1'b0;
    measure(pk, ak, ck, nc, ar, cc, cb, ccol);
    chk("R11 act after refresh", ak, 1);
    chk("R11 col after refresh", ck, 1 + T_RCD);
    chk("R11 col addr", ccol, 140);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule